// File: doc/BRIEF.md
# BCD Calendar Clock Registers

This block keeps calendar time as packed BCD (seconds, minutes, hours in 24-hour form, day-of-week, date, month, year and century). A running set of counters moves forward by one second on every rising edge of a one-pulse-per-second tick input. The tick input is synchronous to the block clock. Rollover follows the calendar: month lengths are honoured and the leap-year rule includes the century.

A host reads and writes the block through a small byte bus: address, write data, write strobe and registered read data. The host never sees the running counters directly. It sees a shadow copy. While the transfer-enable bit in control register B is 1, the shadow follows the counters on every clock. When software clears the bit, the shadow freezes, so a multi-byte read returns one consistent time. The counters keep counting while the shadow is frozen. Time fields written during the freeze are applied to the counters at the moment transfer-enable is set again. Bits 7:5 of the month register are free control bits that are stored apart from the month value.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x00, day-of-week 0x01, date 0x01, month 0x01, year 0x00, century RST_CENTURY, control A 0x00, control B 0x80.
- R2: Each rising edge of `tick_pps` advances seconds by one in BCD. Without a rising edge the running time does not change.
- R3: Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: Date wraps to 0x01 after the last day of the month. April, June, September and November end on 0x30. February ends on 0x29 in a leap year and on 0x28 otherwise. All other months end on 0x31. A year is a leap year if its value is a nonzero multiple of 4. Year 00 is a leap year only when the century is a multiple of 4.
- R5: Month wraps from 0x12 to 0x01 and carries into year. Year wraps from 0x99 to 0x00 and increments century.
- R6: Day-of-week steps once per day carry and wraps from 0x07 to 0x01.
- R7: While control B bit 7 (transfer-enable) is 0, the time registers read back unchanged, yet ticks still advance the running clock. If no time field was written during the freeze, setting the bit back to 1 shows all the time that elapsed.
- R8: Time registers written while transfer-enable is 0 are loaded into the running clock on the write that sets transfer-enable to 1. If a tick arrives on that same clock edge, the loaded value wins.
- R9: Writes to time registers at addresses 0x0–0x7 are ignored while transfer-enable is 1. The month control bits 7:5 are the exception.
- R10: Bits 7:5 of the month register (address 0x5) are writable at any time and read back as written. They never change the 5-bit month value.
- R11: Bits outside the valid widths read 0. The valid widths are: seconds 7, minutes 7, hours 6, day-of-week 3, date 6, month 5, year 8, century 8. Addresses other than 0x0–0x7, 0xE and 0xF read 0x00.
- R12: Read data is registered: `bus_rdata` shows the register addressed on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_pps | input | 1 | One-per-second tick; its rising edge advances time |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with ADDR_W = 5, so addresses 0x10 and above exist on the bus but are unmapped. This lets the bench check that they read zero. It also sets RST_CENTURY = 0x19, a value distinct from the default, so the reset check can tell the parameter really reaches the century register. Because each scenario presets the time through a freeze-and-load sequence, one tick is enough to reach year-end, century, February and day-of-week rollovers. That includes the years 2000 and 2100.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DW = 8;

  localparam logic [3:0] A_SEC  = 4'h0;
  localparam logic [3:0] A_MIN  = 4'h1;
  localparam logic [3:0] A_HR   = 4'h2;
  localparam logic [3:0] A_DOW  = 4'h3;
  localparam logic [3:0] A_DATE = 4'h4;
  localparam logic [3:0] A_MON  = 4'h5;
  localparam logic [3:0] A_YR   = 4'h6;
  localparam logic [3:0] A_CEN  = 4'h7;
  localparam logic [3:0] A_CTLA = 4'hE;
  localparam logic [3:0] A_CTLB = 4'hF;

  localparam int TE_BIT = 7;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  function automatic rtc_time_t reset_time(input logic [7:0] cen);
    rtc_time_t t;
    t      = '0;
    t.cen  = cen;
    t.mon  = 5'h01;
    t.date = 6'h01;
    t.dow  = 3'd1;
    return t;
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cen);
    logic [7:0] yb;
    logic [7:0] cb;
    yb = bcd2bin(yr);
    cb = bcd2bin(cen);
    if (yb != 8'd0) return (yb[1:0] == 2'd0);
    return (cb[1:0] == 2'd0);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    logic [5:0] d;
    case (mon)
      5'h02:                      d = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_tick_edge.sv
module rtc_tick_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic adv
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_in;
  end

  assign adv = tick_in & ~tick_q;

  // R2: one advance per high level, never two in a row
  p_single_adv_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> !adv);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t cur;
  rtc_time_t nxt;

  logic c_s, c_m, c_h, c_d, c_mo, c_y;
  logic [7:0] s_inc, m_inc, h_inc, d_inc, mo_inc, y_inc, c_inc;
  logic [5:0] mday;

  assign s_inc  = bcd_next({1'b0, cur.sec});
  assign m_inc  = bcd_next({1'b0, cur.min});
  assign h_inc  = bcd_next({2'b0, cur.hr});
  assign d_inc  = bcd_next({2'b0, cur.date});
  assign mo_inc = bcd_next({3'b0, cur.mon});
  assign y_inc  = bcd_next(cur.yr);
  assign c_inc  = bcd_next(cur.cen);
  assign mday   = last_day(cur.mon, leap_year(cur.yr, cur.cen));

  assign c_s  = (cur.sec == 7'h59);
  assign c_m  = c_s & (cur.min == 7'h59);
  assign c_h  = c_m & (cur.hr == 6'h23);
  assign c_d  = c_h & (cur.date == mday);
  assign c_mo = c_d & (cur.mon == 5'h12);
  assign c_y  = c_mo & (cur.yr == 8'h99);

  always_comb begin
    nxt     = cur;
    nxt.sec = c_s ? 7'h00 : s_inc[6:0];
    if (c_s) nxt.min = (cur.min == 7'h59) ? 7'h00 : m_inc[6:0];
    if (c_m) nxt.hr  = (cur.hr == 6'h23) ? 6'h00 : h_inc[5:0];
    if (c_h) begin
      nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
      nxt.date = (cur.date == mday) ? 6'h01 : d_inc[5:0];
    end
    if (c_d)  nxt.mon = (cur.mon == 5'h12) ? 5'h01 : mo_inc[4:0];
    if (c_mo) nxt.yr  = (cur.yr == 8'h99) ? 8'h00 : y_inc;
    if (c_y)  nxt.cen = (cur.cen == 8'h99) ? 8'h00 : c_inc;
  end

  always_ff @(posedge clk) begin
    if (rst)       cur <= reset_time(RST_CENTURY);
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end

  assign now = cur;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(cur));
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && cur.sec == 7'h59) |=> (cur.sec == 7'h00));
  p_year_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && c_mo && cur.yr == 8'h99) |=> (cur.yr == 8'h00));
  p_dow_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && c_h && cur.dow == 3'd7) |=> (cur.dow == 3'd1));
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur == $past(load_val)));
endmodule

// File: rtl/rtc_host_view.sv
module rtc_host_view
  import rtc_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  input  rtc_time_t         live,
  output logic [DW-1:0]     rdata,
  output logic              load,
  output rtc_time_t         load_val
);
  rtc_time_t  sh;
  logic [2:0] mon_ctl;
  logic [7:0] ctla;
  logic [6:0] ctlb_rest;
  logic       te;
  logic       dirty;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] r);
    return (a == ADDR_W'(r));
  endfunction

  logic is_time, wr_time, wr_ctlb;
  assign is_time = (addr < ADDR_W'(8));
  assign wr_time = we & ~te & is_time;
  assign wr_ctlb = we & hit(addr, A_CTLB);
  assign load    = wr_ctlb & wdata[TE_BIT] & ~te & dirty;
  assign load_val = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= reset_time(RST_CENTURY);
      mon_ctl   <= '0;
      ctla      <= '0;
      ctlb_rest <= '0;
      te        <= 1'b1;
      dirty     <= 1'b0;
    end else begin
      if (te) sh <= live;
      else if (wr_time) begin
        if (hit(addr, A_SEC))  sh.sec  <= wdata[6:0];
        if (hit(addr, A_MIN))  sh.min  <= wdata[6:0];
        if (hit(addr, A_HR))   sh.hr   <= wdata[5:0];
        if (hit(addr, A_DOW))  sh.dow  <= wdata[2:0];
        if (hit(addr, A_DATE)) sh.date <= wdata[5:0];
        if (hit(addr, A_MON))  sh.mon  <= wdata[4:0];
        if (hit(addr, A_YR))   sh.yr   <= wdata;
        if (hit(addr, A_CEN))  sh.cen  <= wdata;
      end
      if (we && hit(addr, A_MON))  mon_ctl <= wdata[7:5];
      if (we && hit(addr, A_CTLA)) ctla    <= wdata;
      if (wr_ctlb) begin
        te        <= wdata[TE_BIT];
        ctlb_rest <= wdata[6:0];
      end
      if (wr_time)                          dirty <= 1'b1;
      else if (wr_ctlb && wdata[TE_BIT])    dirty <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (hit(addr, A_SEC))  rdata <= {1'b0, sh.sec};
    else if (hit(addr, A_MIN))  rdata <= {1'b0, sh.min};
    else if (hit(addr, A_HR))   rdata <= {2'b0, sh.hr};
    else if (hit(addr, A_DOW))  rdata <= {5'b0, sh.dow};
    else if (hit(addr, A_DATE)) rdata <= {2'b0, sh.date};
    else if (hit(addr, A_MON))  rdata <= {mon_ctl, sh.mon};
    else if (hit(addr, A_YR))   rdata <= sh.yr;
    else if (hit(addr, A_CEN))  rdata <= sh.cen;
    else if (hit(addr, A_CTLA)) rdata <= ctla;
    else if (hit(addr, A_CTLB)) rdata <= {te, ctlb_rest};
    else                        rdata <= '0;
  end

  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!te && !we) |=> $stable(sh));
  p_load_resumes_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> te);
  p_monctl_r10: assert property (@(posedge clk) disable iff (rst)
    (we && hit(addr, A_MON)) |=> (mon_ctl == $past(wdata[7:5])));
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!is_time && !hit(addr, A_CTLA) && !hit(addr, A_CTLB)) |=> (rdata == 8'h00));
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_pps,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata
);
  logic      adv;
  logic      load;
  rtc_time_t live;
  rtc_time_t load_val;

  rtc_tick_edge u_edge (
    .clk(clk), .rst(rst), .tick_in(tick_pps), .adv(adv)
  );

  rtc_calendar_core #(.RST_CENTURY(RST_CENTURY)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .load(load),
    .load_val(load_val), .now(live)
  );

  rtc_host_view #(.ADDR_W(ADDR_W), .RST_CENTURY(RST_CENTURY)) u_view (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .live(live), .rdata(bus_rdata), .load(load), .load_val(load_val)
  );
endmodule

// File: tb/sim_rtc_bcd_regs.sv
module sim_rtc_bcd_regs;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          we = 1'b0;
  logic [7:0]    rdata;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  rtc_bcd_regs #(.ADDR_W(AW), .RST_CENTURY(8'h19)) u0 (
    .clk(clk), .rst(rst), .tick_pps(tick), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); @(posedge clk);
    @(negedge clk); v = rdata;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    n_run++;
    if (v !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, a, v, exp);
    end
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, date, dow, hr, mn, sc);
    wr(5'h0F, 8'h00);
    wr(5'h07, cen); wr(5'h06, yr); wr(5'h05, mon); wr(5'h04, date);
    wr(5'h03, dow); wr(5'h02, hr); wr(5'h01, mn); wr(5'h00, sc);
    wr(5'h0F, 8'h80);
  endtask

  task automatic t_reset;  // R1, R12
    chk("R1", 5'h00, 8'h00); chk("R1", 5'h01, 8'h00); chk("R1", 5'h02, 8'h00);
    chk("R1", 5'h03, 8'h01); chk("R1", 5'h04, 8'h01); chk("R1", 5'h05, 8'h01);
    chk("R1", 5'h06, 8'h00); chk("R1", 5'h07, 8'h19); chk("R1", 5'h0E, 8'h00);
    chk("R12", 5'h0F, 8'h80);
  endtask

  task automatic t_tick;  // R2
    pulse(); pulse(); pulse();
    chk("R2", 5'h00, 8'h03);
    repeat (4) @(negedge clk);
    chk("R2", 5'h00, 8'h03);
  endtask

  task automatic t_year_end;  // R3 R5 R6
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse();
    chk("R3", 5'h00, 8'h00); chk("R3", 5'h01, 8'h00); chk("R3", 5'h02, 8'h00);
    chk("R4", 5'h04, 8'h01); chk("R5", 5'h05, 8'h01); chk("R5", 5'h06, 8'h00);
    chk("R5", 5'h07, 8'h20); chk("R6", 5'h03, 8'h01);
    set_time(8'h20, 8'h15, 8'h06, 8'h10, 8'h02, 8'h10, 8'h59, 8'h59);
    pulse();
    chk("R3", 5'h01, 8'h00); chk("R3", 5'h02, 8'h11); chk("R6", 5'h03, 8'h02);
  endtask

  task automatic t_month(input logic [7:0] cen, yr, mon, date, exp_mon, exp_date);  // R4
    set_time(cen, yr, mon, date, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse();
    chk("R4", 5'h04, exp_date); chk("R4", 5'h05, exp_mon); chk("R6", 5'h03, 8'h04);
  endtask

  task automatic t_freeze;  // R7
    set_time(8'h20, 8'h30, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h10);
    wr(5'h0F, 8'h00);
    repeat (5) pulse();
    chk("R7", 5'h00, 8'h10);
    wr(5'h0F, 8'h80);
    chk("R7", 5'h00, 8'h15);
  endtask

  task automatic t_ignore;  // R9
    wr(5'h00, 8'h30); wr(5'h01, 8'h44);
    chk("R9", 5'h00, 8'h15); chk("R9", 5'h01, 8'h00);
  endtask

  task automatic t_collide;  // R8
    wr(5'h0F, 8'h00); wr(5'h00, 8'h40);
    @(negedge clk); addr = 5'h0F; wdata = 8'h80; we = 1'b1; tick = 1'b1;
    @(posedge clk); #1 we = 1'b0;
    @(negedge clk); tick = 1'b0;
    chk("R8", 5'h00, 8'h40);
    pulse();
    chk("R8", 5'h00, 8'h41);
  endtask

  task automatic t_monctl;  // R10
    wr(5'h05, 8'hE7);
    chk("R10", 5'h05, 8'hE5);
    wr(5'h0F, 8'h00); wr(5'h05, 8'hA3);
    chk("R10", 5'h05, 8'hA3);
    wr(5'h0F, 8'h80);
    chk("R10", 5'h05, 8'hA3);
  endtask

  task automatic t_masks;  // R11
    chk("R11", 5'h08, 8'h00); chk("R11", 5'h0C, 8'h00); chk("R11", 5'h13, 8'h00);
    wr(5'h0F, 8'h00);
    wr(5'h00, 8'hFF); wr(5'h02, 8'hFF); wr(5'h03, 8'hFF); wr(5'h04, 8'hFF);
    chk("R11", 5'h00, 8'h7F); chk("R11", 5'h02, 8'h3F);
    chk("R11", 5'h03, 8'h07); chk("R11", 5'h04, 8'h3F);
    set_time(8'h20, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_tick();
    t_year_end();
    t_month(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    t_month(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    t_month(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    t_month(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h01);
    t_month(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    t_month(8'h20, 8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    t_month(8'h20, 8'h25, 8'h01, 8'h30, 8'h01, 8'h31);
    t_freeze();
    t_ignore();
    t_collide();
    t_monctl();
    t_masks();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule